// File: doc/BRIEF.md
# Three-Channel Timer Host Register Interface

This block sits between an 8-bit host bus and three counting channels of an interval timer. The host selects either one of the three counters or the control register with a two-bit address. It writes control words that set each channel's mode, counting base and byte access format. It then writes the initial count one or two bytes at a time. Reads from a counter address return either the channel's running count or a frozen copy of it.

Every register in the block works in the host clock domain. A bus cycle lasts exactly one clock. It is a write while the chip select and the write strobe are both low, and a read while the chip select and the read strobe are low and the write strobe is high. Toward each channel the block drives the mode, the BCD flag, the assembled count, a one-cycle load strobe, a one-cycle first-byte strobe and a one-cycle control-word strobe. From each channel it takes the live count, the output pin state and the null-count flag. The block can freeze a count for a later read. It can also capture a packed status byte for one or more channels through a single broadcast command.

Top module: `tmr_host_if`

## Requirements
- R1: When `cs_n` is high, neither data writes nor control writes change any channel output or strobe.
- R2: A control write has address 3, select bits 7:6 equal to 0, 1 or 2, and format bits 5:4 not equal to 00. One cycle later it raises `ch_ctrl` of that channel for one cycle and presents bits 3:1 as the mode and bit 0 as the BCD flag.
- R3: In format 10 (low byte only), a data write of byte B gives the count 0x00B, with `ch_load` high for one cycle in the cycle after the write.
- R4: In format 01 (high byte only), a data write of byte B gives the count 0xB00 with a one-cycle `ch_load`.
- R5: In format 11, the first data write raises only `ch_first`. The second raises `ch_load` and presents {second byte, first byte}.
- R6: A control write for a channel returns that channel's byte pointer to the low byte.
- R7: An unfrozen read returns bytes of the live count. Format 10 gives the low byte and format 01 gives the high byte. Format 11 alternates low, then high.
- R8: A control write to address 3 with bits 5:4 = 00 freezes the selected channel's live count. Further freeze commands are ignored until the frozen value has been read out fully in the programmed format, after which reads are live again.
- R9: A control write with bits 7:6 = 11 is a broadcast command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 4 low captures status and bit 5 low freezes the count. The status byte is {OUT, null count, format[1:0], mode[2:0], BCD}, from bit 7 down to bit 0.
- R10: A captured status byte is returned by the next read of that channel, before any frozen count, and does not move the byte pointer. A second status capture before that read is ignored.
- R11: After reset every channel has mode 0, BCD 0, count 0 and no strobes, and `dout` is 0. Data writes to a channel that has had no control write since reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | 0..2 counter, 3 control register |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data, 0 when no counter read |
| ch_mode | output | 9 | Mode per channel, 3 bits each |
| ch_bcd | output | 3 | BCD select per channel |
| ch_count | output | 48 | Assembled count per channel, 16 bits each |
| ch_load | output | 3 | One-cycle new-count strobe per channel |
| ch_first | output | 3 | One-cycle first-of-two-bytes strobe per channel |
| ch_ctrl | output | 3 | One-cycle control-word strobe per channel |
| ch_live | input | 48 | Running count from each channel |
| ch_out | input | 3 | OUT pin state of each channel |
| ch_null | input | 3 | Null-count flag of each channel |

## Verification
Most internal errors in this block show up on the next read or the next data write to the same channel. A byte pointer in the wrong state swaps the low and high bytes on that read, or it raises `ch_load` one write early. A freeze flag that is stuck or released too soon makes `dout` follow `ch_live` when it should hold, or hold when it should follow. A status flag that is not cleared puts the status byte where a count byte belongs on the following read. A wrongly decoded control word shows up on `ch_ctrl` and `ch_mode` one cycle after the write. The stimulus therefore changes the live count between the freeze and the read, so that a frozen value and a live value can always be told apart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        FMT_FREEZE = 2'b00,
        FMT_HI     = 2'b01,
        FMT_LO     = 2'b10,
        FMT_LOHI   = 2'b11
    } acc_fmt_t;

    typedef struct packed {
        logic [1:0] sel;
        acc_fmt_t   fmt;
        logic [2:0] mode;
        logic       bcd;
    } ctl_word_t;

    localparam logic [1:0] CTL_ADDR  = 2'd3;
    localparam logic [1:0] SEL_BCAST = 2'd3;

endpackage

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 8
) (
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output ctl_word_t     cw,
    output logic          rd_act,
    output logic [NCH-1:0] cw_prog,
    output logic [NCH-1:0] cnt_frz,
    output logic [NCH-1:0] sts_cap,
    output logic [NCH-1:0] d_wr,
    output logic [NCH-1:0] d_rd
);

    logic wr_act;
    logic ctl_wr;

    always_comb begin
        wr_act = !cs_n && !wr_n;
        rd_act = !cs_n && !rd_n && wr_n;
        ctl_wr = wr_act && (addr == CTL_ADDR);
        cw     = ctl_word_t'(din[7:0]);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [1:0] IDX = 2'(i);
        always_comb begin
            cw_prog[i] = ctl_wr && (cw.sel == IDX) && (cw.fmt != FMT_FREEZE);
            cnt_frz[i] = ctl_wr && (((cw.sel == IDX) && (cw.fmt == FMT_FREEZE)) ||
                                    ((cw.sel == SEL_BCAST) && !din[5] && din[1+i]));
            sts_cap[i] = ctl_wr && (cw.sel == SEL_BCAST) && !din[4] && din[1+i];
            d_wr[i]    = wr_act && (addr == IDX);
            d_rd[i]    = rd_act && (addr == IDX);
        end
    end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  ctl_word_t      cw,
    input  logic           cw_prog,
    input  logic           cnt_frz,
    input  logic           sts_cap,
    input  logic           d_wr,
    input  logic           d_rd,
    input  logic [DW-1:0]  din,
    input  logic [2*DW-1:0] live,
    input  logic           out_pin,
    input  logic           null_flag,
    output logic [2:0]     mode,
    output logic           bcd,
    output logic [2*DW-1:0] count,
    output logic           load,
    output logic           first,
    output logic           ctrl,
    output logic [DW-1:0]  rd_byte
);

    localparam int CW = 2 * DW;

    typedef struct packed {
        logic [2:0]    mode;
        acc_fmt_t      fmt;
        logic          bcd;
        logic          ptr;
        logic [DW-1:0] lo_hold;
        logic [CW-1:0] cnt;
        logic          load;
        logic          first;
        logic          ctrl;
        logic          frz_v;
        logic [CW-1:0] frz;
        logic          sts_v;
        logic [DW-1:0] sts;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [CW-1:0] rd_src;
    logic          take_hi;

    always_comb begin
        st_d       = st_q;
        st_d.load  = 1'b0;
        st_d.first = 1'b0;
        st_d.ctrl  = 1'b0;

        if (cw_prog) begin
            st_d.mode  = cw.mode;
            st_d.fmt   = cw.fmt;
            st_d.bcd   = cw.bcd;
            st_d.ptr   = 1'b0;
            st_d.frz_v = 1'b0;
            st_d.sts_v = 1'b0;
            st_d.ctrl  = 1'b1;
        end

        if (cnt_frz && !st_q.frz_v) begin
            st_d.frz_v = 1'b1;
            st_d.frz   = live;
        end

        if (sts_cap && !st_q.sts_v) begin
            st_d.sts_v = 1'b1;
            st_d.sts   = DW'({out_pin, null_flag, st_q.fmt, st_q.mode, st_q.bcd});
        end

        if (d_wr) begin
            unique case (st_q.fmt)
                FMT_LO: begin
                    st_d.cnt  = {{DW{1'b0}}, din};
                    st_d.load = 1'b1;
                end
                FMT_HI: begin
                    st_d.cnt  = {din, {DW{1'b0}}};
                    st_d.load = 1'b1;
                end
                FMT_LOHI: begin
                    if (!st_q.ptr) begin
                        st_d.lo_hold = din;
                        st_d.first   = 1'b1;
                        st_d.ptr     = 1'b1;
                    end else begin
                        st_d.cnt  = {din, st_q.lo_hold};
                        st_d.load = 1'b1;
                        st_d.ptr  = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (d_rd) begin
            if (st_q.sts_v) begin
                st_d.sts_v = 1'b0;
            end else begin
                if (st_q.fmt == FMT_LOHI) begin
                    st_d.ptr = !st_q.ptr;
                end
                if ((st_q.fmt != FMT_LOHI) || st_q.ptr) begin
                    st_d.frz_v = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: 3'd0, fmt: FMT_FREEZE, bcd: 1'b0, ptr: 1'b0,
                      lo_hold: '0, cnt: '0, load: 1'b0, first: 1'b0,
                      ctrl: 1'b0, frz_v: 1'b0, frz: '0, sts_v: 1'b0, sts: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_src  = st_q.frz_v ? st_q.frz : live;
        take_hi = (st_q.fmt == FMT_HI) || ((st_q.fmt == FMT_LOHI) && st_q.ptr);
        if (st_q.sts_v) begin
            rd_byte = st_q.sts;
        end else if (take_hi) begin
            rd_byte = rd_src[CW-1:DW];
        end else begin
            rd_byte = rd_src[DW-1:0];
        end
        mode  = st_q.mode;
        bcd   = st_q.bcd;
        count = st_q.cnt;
        load  = st_q.load;
        first = st_q.first;
        ctrl  = st_q.ctrl;
    end

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux #(
    parameter int NCH = 3,
    parameter int DW  = 8
) (
    input  logic              rd_act,
    input  logic [1:0]        addr,
    input  logic [NCH*DW-1:0] rd_bytes,
    output logic [DW-1:0]     dout
);

    always_comb begin
        dout = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_act && (addr == 2'(i))) begin
                dout = rd_bytes[i*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int DW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                rd_n,
    input  logic                wr_n,
    input  logic [1:0]          addr,
    input  logic [DW-1:0]       din,
    output logic [DW-1:0]       dout,
    output logic [NCH*3-1:0]    ch_mode,
    output logic [NCH-1:0]      ch_bcd,
    output logic [NCH*2*DW-1:0] ch_count,
    output logic [NCH-1:0]      ch_load,
    output logic [NCH-1:0]      ch_first,
    output logic [NCH-1:0]      ch_ctrl,
    input  logic [NCH*2*DW-1:0] ch_live,
    input  logic [NCH-1:0]      ch_out,
    input  logic [NCH-1:0]      ch_null
);

    localparam int CW = 2 * DW;

    ctl_word_t          cw;
    logic               rd_act;
    logic [NCH-1:0]     cw_prog, cnt_frz, sts_cap, d_wr, d_rd;
    logic [NCH*DW-1:0]  rd_bytes;

    tmr_bus_dec #(.NCH(NCH), .DW(DW)) u_dec (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .din     (din),
        .cw      (cw),
        .rd_act  (rd_act),
        .cw_prog (cw_prog),
        .cnt_frz (cnt_frz),
        .sts_cap (sts_cap),
        .d_wr    (d_wr),
        .d_rd    (d_rd)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        tmr_chan_regs #(.DW(DW)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .cw        (cw),
            .cw_prog   (cw_prog[i]),
            .cnt_frz   (cnt_frz[i]),
            .sts_cap   (sts_cap[i]),
            .d_wr      (d_wr[i]),
            .d_rd      (d_rd[i]),
            .din       (din),
            .live      (ch_live[i*CW +: CW]),
            .out_pin   (ch_out[i]),
            .null_flag (ch_null[i]),
            .mode      (ch_mode[i*3 +: 3]),
            .bcd       (ch_bcd[i]),
            .count     (ch_count[i*CW +: CW]),
            .load      (ch_load[i]),
            .first     (ch_first[i]),
            .ctrl      (ch_ctrl[i]),
            .rd_byte   (rd_bytes[i*DW +: DW])
        );
    end

    tmr_rd_mux #(.NCH(NCH), .DW(DW)) u_mux (
        .rd_act   (rd_act),
        .addr     (addr),
        .rd_bytes (rd_bytes),
        .dout     (dout)
    );

endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk #(
    parameter int NCH = 3,
    parameter int DW  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                wr_n,
    input logic [1:0]          addr,
    input logic [DW-1:0]       din,
    input logic [NCH*3-1:0]    ch_mode,
    input logic [NCH*2*DW-1:0] ch_count,
    input logic [NCH-1:0]      ch_load,
    input logic [NCH-1:0]      ch_first,
    input logic [NCH-1:0]      ch_ctrl
);

    localparam int CW = 2 * DW;

    a_r2_ctrl_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_ctrl));

    a_r1_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_load));

    for (genvar i = 0; i < NCH; i++) begin : g_prop
        localparam logic [1:0] IDX = 2'(i);

        a_r2_ctrl_follows_word: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !wr_n && addr == 2'd3 && din[7:6] == IDX && din[5:4] != 2'b00)
            |=> ch_ctrl[i]);

        a_r1_load_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            ch_load[i] |-> $past(!cs_n && !wr_n && addr == IDX));

        a_r5_first_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
            ch_first[i] |-> $past(!cs_n && !wr_n && addr == IDX));

        a_r5_first_not_load: assert property (@(posedge clk) disable iff (!rst_n)
            ch_first[i] |-> !ch_load[i]);

        a_r3_count_moves_on_load: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(ch_count[i*CW +: CW]) |-> ch_load[i]);

        a_r2_mode_moves_on_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(ch_mode[i*3 +: 3]) |-> ch_ctrl[i]);
    end

endmodule

bind tmr_host_if tmr_host_if_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .addr     (addr),
    .din      (din),
    .ch_mode  (ch_mode),
    .ch_count (ch_count),
    .ch_load  (ch_load),
    .ch_first (ch_first),
    .ch_ctrl  (ch_ctrl)
);

// File: tb/tb_tmr_host_if.sv
module tb_tmr_host_if;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  din = 8'h00;
    logic [7:0]  dout;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [47:0] ch_count;
    logic [2:0]  ch_load;
    logic [2:0]  ch_first;
    logic [2:0]  ch_ctrl;
    logic [47:0] ch_live = 48'h0;
    logic [2:0]  ch_out = 3'b001;
    logic [2:0]  ch_null = 3'b000;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    tmr_host_if dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
        .ch_count(ch_count), .ch_load(ch_load), .ch_first(ch_first),
        .ch_ctrl(ch_ctrl), .ch_live(ch_live), .ch_out(ch_out), .ch_null(ch_null)
    );

    // op: 1 = bus write, 2 = bus read and compare; fields {op, addr, data, live0}
    localparam int NV = 29;
    localparam logic [27:0] VEC [NV] = '{
        {2'd1, 2'd3, 8'h34, 16'h1234},  // R6 ch0 two-byte, mode 2
        {2'd2, 2'd0, 8'h34, 16'h1234},  // R7 low byte live
        {2'd2, 2'd0, 8'h12, 16'h1234},  // R7 high byte live
        {2'd1, 2'd3, 8'h00, 16'h1234},  // R8 freeze
        {2'd2, 2'd0, 8'h34, 16'h5678},  // R8 frozen low
        {2'd1, 2'd3, 8'h00, 16'h9ABC},  // R8 second freeze ignored
        {2'd2, 2'd0, 8'h12, 16'h9ABC},  // R8 frozen high, releases
        {2'd2, 2'd0, 8'hBC, 16'h9ABC},  // R8 live again
        {2'd2, 2'd0, 8'h9A, 16'h9ABC},  // R7
        {2'd1, 2'd3, 8'h14, 16'h4321},  // R7 high-only format
        {2'd2, 2'd0, 8'h43, 16'h4321},  // R7
        {2'd2, 2'd0, 8'h43, 16'h4321},  // R7
        {2'd1, 2'd3, 8'h24, 16'h4321},  // R7 low-only format
        {2'd2, 2'd0, 8'h21, 16'h4321},  // R7
        {2'd1, 2'd3, 8'h00, 16'h4321},  // R8 freeze in low-only
        {2'd2, 2'd0, 8'h21, 16'h7777},  // R8 single read releases
        {2'd2, 2'd0, 8'h77, 16'h7777},  // R8
        {2'd1, 2'd3, 8'h34, 16'h1234},  // R6
        {2'd2, 2'd0, 8'h34, 16'h1234},  // R6 pointer now high
        {2'd1, 2'd3, 8'h34, 16'h1234},  // R6 control word resets pointer
        {2'd2, 2'd0, 8'h34, 16'h1234},  // R6 low again
        {2'd1, 2'd3, 8'hE2, 16'h1234},  // R9 status capture ch0
        {2'd2, 2'd0, 8'hB4, 16'h1234},  // R9 status byte
        {2'd2, 2'd0, 8'h12, 16'h1234},  // R10 pointer untouched by status
        {2'd1, 2'd3, 8'hC2, 16'h5555},  // R9 status + count capture
        {2'd2, 2'd0, 8'hB4, 16'hAAAA},  // R10 status first
        {2'd2, 2'd0, 8'h55, 16'hAAAA},  // R10 then frozen low
        {2'd2, 2'd0, 8'h55, 16'hAAAA},  // R10 frozen high
        {2'd2, 2'd0, 8'hAA, 16'hAAAA}   // R8 released
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic sel, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = !sel; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 v = dout;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 mode", 32'(ch_mode), 32'h0);
        chk("R11 bcd", 32'(ch_bcd), 32'h0);
        chk("R11 count", ch_count[31:0], 32'h0);
        chk("R11 strobes", 32'({ch_load, ch_first, ch_ctrl}), 32'h0);
        chk("R11 dout", 32'(dout), 32'h0);

        // R11 data write before any control word ignored
        bus_wr(1'b1, 2'd1, 8'h77);
        chk("R11 unprog load", 32'({ch_load, ch_first}), 32'h0);
        chk("R11 unprog count", 32'(ch_count[31:16]), 32'h0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            ch_live[15:0] = VEC[k][15:0];
            if (VEC[k][27:26] == 2'd1) begin
                bus_wr(1'b1, VEC[k][25:24], VEC[k][23:16]);
            end else begin
                bus_rd(VEC[k][25:24], v);
                chk($sformatf("R7/R8/R9/R10 vec %0d", k), 32'(v), 32'(VEC[k][23:16]));
            end
        end

        // R2 control word fields and strobe
        bus_wr(1'b1, 2'd3, 8'h7B);
        chk("R2 ctrl strobe", 32'(ch_ctrl), 32'h2);
        chk("R2 mode", 32'(ch_mode[5:3]), 32'h5);
        chk("R2 bcd", 32'(ch_bcd[1]), 32'h1);
        @(negedge clk);
        chk("R2 strobe one cycle", 32'(ch_ctrl), 32'h0);

        // R5 two-byte write
        bus_wr(1'b1, 2'd1, 8'hCD);
        chk("R5 first strobe", 32'({ch_first, ch_load}), 32'({3'b010, 3'b000}));
        bus_wr(1'b1, 2'd1, 8'hAB);
        chk("R5 load strobe", 32'({ch_first, ch_load}), 32'({3'b000, 3'b010}));
        chk("R5 count", 32'(ch_count[31:16]), 32'hABCD);

        // R1 chip select high
        bus_wr(1'b0, 2'd1, 8'h11);
        chk("R1 no load", 32'({ch_load, ch_first}), 32'h0);
        chk("R1 count kept", 32'(ch_count[31:16]), 32'hABCD);
        bus_wr(1'b0, 2'd3, 8'h52);
        chk("R1 no ctrl", 32'(ch_ctrl), 32'h0);
        chk("R1 mode kept", 32'(ch_mode[5:3]), 32'h5);

        // R3 low-only
        bus_wr(1'b1, 2'd3, 8'hA0);
        bus_wr(1'b1, 2'd2, 8'h5A);
        chk("R3 load", 32'(ch_load), 32'h4);
        chk("R3 count", 32'(ch_count[47:32]), 32'h005A);

        // R4 high-only
        bus_wr(1'b1, 2'd3, 8'h90);
        bus_wr(1'b1, 2'd2, 8'h5A);
        chk("R4 load", 32'(ch_load), 32'h4);
        chk("R4 count", 32'(ch_count[47:32]), 32'h5A00);

        // R9 broadcast status on ch1 and ch2
        ch_out = 3'b101; ch_null = 3'b010;
        bus_wr(1'b1, 2'd3, 8'hEC);
        bus_rd(2'd1, v);
        chk("R9 ch1 status", 32'(v), 32'h7B);
        bus_rd(2'd2, v);
        chk("R9 ch2 status", 32'(v), 32'h90);

        // R10 second capture ignored, then released
        bus_wr(1'b1, 2'd3, 8'hE4);
        ch_out = 3'b111; ch_null = 3'b000;
        bus_wr(1'b1, 2'd3, 8'hE4);
        bus_rd(2'd1, v);
        chk("R10 held status", 32'(v), 32'h7B);
        ch_live[31:16] = 16'hBEEF;
        bus_rd(2'd1, v);
        chk("R10 status released", 32'(v), 32'hEF);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule